// File: doc/BRIEF.md
# Gated Photon-Detector Acquisition Sequencer

This block drives the digital control of one gated single-photon pixel and counts how often the pixel reports a hit. Each repetition has two parts. The active part opens with a short recharge pulse and keeps the inhibit line high. The off part pulls the inhibit line low and then raises a readout-select strobe, so that the pixel's stored bit appears on its output. A latch-sample enable rises with the recharge pulse and falls a fixed margin before the inhibit line drops. This keeps a false hit from being stored while the sensor is being disabled.

Software sets the active window, the off period and the number of repetitions in clock cycles, then pulses `start`. The block runs every repetition. It samples the pixel bit on the last cycle of each readout strobe and adds one count when that bit is 1. When all repetitions are finished it holds the result with a done flag. If the settings would break the strobe ordering, the block refuses to start and raises an error flag instead.

Top module: `gated_acq_seq`

## Requirements
- R1: After an accepted `start` (sampled high on a clock edge while not busy), the next cycle is cycle 0 of repetition 0. Each repetition begins with `recharge` high for exactly RCH_CYC cycles.
- R2: `sample_en` goes high in the same cycle as `recharge` and stays high for `cfg_obs` - LATCH_MARGIN cycles. It is therefore low for the last LATCH_MARGIN cycles of the active window.
- R3: `inhibit_n` is high for exactly `cfg_obs` cycles per repetition. It is low at all other times, including idle, done and error. `recharge` and `sample_en` are only ever high while `inhibit_n` is high.
- R4: Between one active window and the next, `inhibit_n` stays low for exactly `cfg_off` cycles. A repetition therefore lasts `cfg_obs` + `cfg_off` cycles. The configuration is captured at start, so later changes to the `cfg_*` inputs have no effect on the run.
- R5: `read_sel` is high for RD_CYC cycles. It starts RD_GAP cycles after `inhibit_n` falls and is never high while `inhibit_n` is high.
- R6: `pix_bit` is sampled only on the last cycle of `read_sel`. A 1 there adds one to `hit_count`, which shows the new value in the following cycle. The value of `pix_bit` in any other cycle has no effect.
- R7: `hit_count` saturates at 2^HIT_W-1 and never wraps. `sat` is high exactly when `hit_count` equals that value.
- R8: After `cfg_reps` repetitions, `done` rises in the cycle after the last off cycle. `done` and `hit_count` then hold until the next accepted `start`. A `start` while `busy` is ignored.
- R9: A start is rejected if `cfg_obs` < RCH_CYC + LATCH_MARGIN, if `cfg_off` < RD_GAP + RD_CYC, or if `cfg_reps` = 0. On rejection, `cfg_err` rises in the next cycle and stays high until the next start, and no strobe is produced.
- R10: Any start that is sampled while not busy clears `hit_count` to 0 in the next cycle, whether the start is accepted or rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single fast clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a measurement when not busy |
| cfg_obs | input | CNT_W | Active-window length in cycles |
| cfg_off | input | CNT_W | Off-period length in cycles |
| cfg_reps | input | REP_W | Number of repetitions |
| pix_bit | input | 1 | One-bit pixel output (1 = avalanche latched) |
| recharge | output | 1 | Sensor recharge pulse opening each window |
| inhibit_n | output | 1 | Active-low inhibit; high means sensor enabled |
| sample_en | output | 1 | Pixel latch sampling enable |
| read_sel | output | 1 | Pixel readout-select strobe |
| busy | output | 1 | A measurement is running |
| done | output | 1 | Measurement finished, result held |
| cfg_err | output | 1 | Last start was rejected |
| sat | output | 1 | Hit counter at its maximum |
| hit_count | output | HIT_W | Number of repetitions with a latched hit |

## Verification
The bench builds the block with RCH_CYC=2, LATCH_MARGIN=3, RD_GAP=1 and RD_CYC=4, so that the minimum window is 5 cycles and the minimum off period is 5 cycles. It runs window and off settings at exactly those limits and one below them. HIT_W is set to 4, so the counter saturates at 15. A 20-repetition run with a hit in every window then reaches saturation and keeps going past it within a few hundred cycles. REP_W=8 keeps the repetition counts short, while the 12-bit timing fields still allow settings in the range of 10 to 20 cycles.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACT  = 3'd1,
      ST_OFF  = 3'd2,
      ST_DONE = 3'd3,
      ST_ERR  = 3'd4
   } gseq_st_e;
endpackage

// File: rtl/gseq_cfg_check.sv
module gseq_cfg_check #(
   parameter int CNT_W        = 12,
   parameter int REP_W        = 17,
   parameter int RCH_CYC      = 2,
   parameter int LATCH_MARGIN = 3,
   parameter int RD_GAP       = 1,
   parameter int RD_CYC       = 4
) (
   input  logic [CNT_W-1:0] obs,
   input  logic [CNT_W-1:0] off,
   input  logic [REP_W-1:0] reps,
   output logic             ok
);
   localparam logic [CNT_W-1:0] OBS_MIN = CNT_W'(RCH_CYC + LATCH_MARGIN);
   localparam logic [CNT_W-1:0] OFF_MIN = CNT_W'(RD_GAP + RD_CYC);

   always_comb begin
      ok = (obs >= OBS_MIN) && (off >= OFF_MIN) && (reps != '0);
   end
endmodule

// File: rtl/gseq_phase.sv
module gseq_phase
   import gseq_pkg::*;
#(
   parameter int CNT_W        = 12,
   parameter int REP_W        = 17,
   parameter int RCH_CYC      = 2,
   parameter int LATCH_MARGIN = 3,
   parameter int RD_GAP       = 1,
   parameter int RD_CYC       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cfg_ok,
   input  logic [CNT_W-1:0] cfg_obs,
   input  logic [CNT_W-1:0] cfg_off,
   input  logic [REP_W-1:0] cfg_reps,
   output logic             recharge,
   output logic             inhibit_n,
   output logic             sample_en,
   output logic             read_sel,
   output logic             smp_strobe,
   output logic             clr_strobe,
   output logic             busy,
   output logic             done,
   output logic             cfg_err
);
   localparam logic [CNT_W-1:0] RCH_END = CNT_W'(RCH_CYC);
   localparam logic [CNT_W-1:0] MARGIN  = CNT_W'(LATCH_MARGIN);
   localparam logic [CNT_W-1:0] RD_BEG  = CNT_W'(RD_GAP);
   localparam logic [CNT_W-1:0] RD_END  = CNT_W'(RD_GAP + RD_CYC);
   localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_GAP + RD_CYC - 1);

   gseq_st_e         st_q;
   logic [CNT_W-1:0] tcnt_q;
   logic [REP_W-1:0] rep_q;
   logic [CNT_W-1:0] obs_q;
   logic [CNT_W-1:0] off_q;
   logic [REP_W-1:0] reps_q;
   logic             idle_like;

   always_comb begin
      idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         tcnt_q <= '0;
         rep_q  <= '0;
         obs_q  <= '0;
         off_q  <= '0;
         reps_q <= '0;
      end else begin
         unique case (st_q)
            ST_ACT: begin
               if (tcnt_q == obs_q - 1'b1) begin
                  tcnt_q <= '0;
                  st_q   <= ST_OFF;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            ST_OFF: begin
               if (tcnt_q == off_q - 1'b1) begin
                  tcnt_q <= '0;
                  if (rep_q == reps_q - 1'b1) begin
                     st_q <= ST_DONE;
                  end else begin
                     rep_q <= rep_q + 1'b1;
                     st_q  <= ST_ACT;
                  end
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            default: begin
               if (start) begin
                  obs_q  <= cfg_obs;
                  off_q  <= cfg_off;
                  reps_q <= cfg_reps;
                  tcnt_q <= '0;
                  rep_q  <= '0;
                  st_q   <= cfg_ok ? ST_ACT : ST_ERR;
               end
            end
         endcase
      end
   end

   always_comb begin
      inhibit_n  = (st_q == ST_ACT);
      recharge   = (st_q == ST_ACT) && (tcnt_q < RCH_END);
      sample_en  = (st_q == ST_ACT) && (tcnt_q < obs_q - MARGIN);
      read_sel   = (st_q == ST_OFF) && (tcnt_q >= RD_BEG) && (tcnt_q < RD_END);
      smp_strobe = (st_q == ST_OFF) && (tcnt_q == RD_LAST);
      clr_strobe = start && idle_like;
      busy       = !idle_like;
      done       = (st_q == ST_DONE);
      cfg_err    = (st_q == ST_ERR);
   end
endmodule

// File: rtl/gseq_hit_acc.sv
module gseq_hit_acc #(
   parameter int HIT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [HIT_W-1:0] count,
   output logic             full
);
   localparam logic [HIT_W-1:0] TOP = {HIT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && (count != TOP)) begin
         count <= count + 1'b1;
      end
   end

   always_comb begin
      full = (count == TOP);
   end
endmodule

// File: rtl/gated_acq_seq.sv
module gated_acq_seq #(
   parameter int CNT_W        = 12,
   parameter int REP_W        = 17,
   parameter int HIT_W        = 17,
   parameter int RCH_CYC      = 2,
   parameter int LATCH_MARGIN = 3,
   parameter int RD_GAP       = 1,
   parameter int RD_CYC       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cfg_obs,
   input  logic [CNT_W-1:0] cfg_off,
   input  logic [REP_W-1:0] cfg_reps,
   input  logic             pix_bit,
   output logic             recharge,
   output logic             inhibit_n,
   output logic             sample_en,
   output logic             read_sel,
   output logic             busy,
   output logic             done,
   output logic             cfg_err,
   output logic             sat,
   output logic [HIT_W-1:0] hit_count
);
   localparam int TIME_NEED = (RCH_CYC + LATCH_MARGIN > RD_GAP + RD_CYC) ?
                              (RCH_CYC + LATCH_MARGIN) : (RD_GAP + RD_CYC);

   generate
      if (RCH_CYC < 1 || LATCH_MARGIN < 1 || RD_CYC < 1 || RD_GAP < 0) begin : g_bad_timing
         $error("gated_acq_seq: strobe lengths and margin must be positive");
      end
      if (TIME_NEED >= (1 << CNT_W)) begin : g_bad_cnt_w
         $error("gated_acq_seq: CNT_W too narrow for strobe layout");
      end
      if (HIT_W < 1 || REP_W < 1) begin : g_bad_width
         $error("gated_acq_seq: counter widths must be positive");
      end
   endgenerate

   logic cfg_ok;
   logic smp_strobe;
   logic clr_strobe;

   gseq_cfg_check #(
      .CNT_W(CNT_W), .REP_W(REP_W), .RCH_CYC(RCH_CYC),
      .LATCH_MARGIN(LATCH_MARGIN), .RD_GAP(RD_GAP), .RD_CYC(RD_CYC)
   ) u_cfg (
      .obs  (cfg_obs),
      .off  (cfg_off),
      .reps (cfg_reps),
      .ok   (cfg_ok)
   );

   gseq_phase #(
      .CNT_W(CNT_W), .REP_W(REP_W), .RCH_CYC(RCH_CYC),
      .LATCH_MARGIN(LATCH_MARGIN), .RD_GAP(RD_GAP), .RD_CYC(RD_CYC)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_ok     (cfg_ok),
      .cfg_obs    (cfg_obs),
      .cfg_off    (cfg_off),
      .cfg_reps   (cfg_reps),
      .recharge   (recharge),
      .inhibit_n  (inhibit_n),
      .sample_en  (sample_en),
      .read_sel   (read_sel),
      .smp_strobe (smp_strobe),
      .clr_strobe (clr_strobe),
      .busy       (busy),
      .done       (done),
      .cfg_err    (cfg_err)
   );

   gseq_hit_acc #(.HIT_W(HIT_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_strobe),
      .inc   (smp_strobe && pix_bit),
      .count (hit_count),
      .full  (sat)
   );
endmodule

// File: rtl/gseq_chk.sv
module gseq_chk #(
   parameter int HIT_W   = 17,
   parameter int RCH_CYC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             recharge,
   input logic             inhibit_n,
   input logic             sample_en,
   input logic             read_sel,
   input logic             busy,
   input logic             done,
   input logic             cfg_err,
   input logic             sat,
   input logic [HIT_W-1:0] hit_count
);
   logic [15:0] rch_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rch_run <= '0;
      else if (recharge) rch_run <= rch_run + 1'b1;
      else               rch_run <= '0;
   end

   a_r1_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(recharge) |-> (rch_run == 16'(RCH_CYC)));

   a_r2_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recharge) |-> $rose(sample_en));

   a_r2_margin: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inhibit_n) |-> (!sample_en && !$past(sample_en)));

   a_r3_gate_order: assert property (@(posedge clk) disable iff (!rst_n)
      (recharge || sample_en) |-> inhibit_n);

   a_r5_read_off: assert property (@(posedge clk) disable iff (!rst_n)
      read_sel |-> !inhibit_n);

   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ((hit_count == $past(hit_count)) ||
                  (hit_count == HIT_W'($past(hit_count) + 1'b1))));

   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && !start) |=> sat);

   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(hit_count)));

   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!inhibit_n && !recharge && !read_sel && !busy && !done));

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (hit_count == '0));
endmodule

bind gated_acq_seq gseq_chk #(.HIT_W(HIT_W), .RCH_CYC(RCH_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .recharge  (recharge),
   .inhibit_n (inhibit_n),
   .sample_en (sample_en),
   .read_sel  (read_sel),
   .busy      (busy),
   .done      (done),
   .cfg_err   (cfg_err),
   .sat       (sat),
   .hit_count (hit_count)
);

// File: tb/sim_gated_acq_seq.sv
module sim_gated_acq_seq;
   localparam int CNT_W = 12;
   localparam int REP_W = 8;
   localparam int HIT_W = 4;
   localparam int RCH   = 2;
   localparam int MARG  = 3;
   localparam int GAP   = 1;
   localparam int RDC   = 4;
   localparam int HMAX  = (1 << HIT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] cfg_obs = '0;
   logic [CNT_W-1:0] cfg_off = '0;
   logic [REP_W-1:0] cfg_reps = '0;
   logic             pix_bit = 1'b0;
   logic             recharge, inhibit_n, sample_en, read_sel;
   logic             busy, done, cfg_err, sat;
   logic [HIT_W-1:0] hit_count;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   gated_acq_seq #(
      .CNT_W(CNT_W), .REP_W(REP_W), .HIT_W(HIT_W), .RCH_CYC(RCH),
      .LATCH_MARGIN(MARG), .RD_GAP(GAP), .RD_CYC(RDC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_obs(cfg_obs),
      .cfg_off(cfg_off), .cfg_reps(cfg_reps), .pix_bit(pix_bit),
      .recharge(recharge), .inhibit_n(inhibit_n), .sample_en(sample_en),
      .read_sel(read_sel), .busy(busy), .done(done), .cfg_err(cfg_err),
      .sat(sat), .hit_count(hit_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int strobes();
      return {25'd0, recharge, sample_en, inhibit_n, read_sel, busy, done, cfg_err};
   endfunction

   // accepted start pulse; returns at the falling edge of cycle 0
   task automatic pulse_start(input int obs, input int off, input int reps);
      @(negedge clk);
      cfg_obs  = CNT_W'(obs);
      cfg_off  = CNT_W'(off);
      cfg_reps = REP_W'(reps);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   // full run checked cycle by cycle against a timeline built from R1-R8
   task automatic run_case(input string name, input int obs, input int off,
                           input int reps, input logic [31:0] pat, input int mid_at);
      int per;
      int total;
      int exp_cnt;
      per     = obs + off;
      total   = per * reps;
      exp_cnt = 0;
      pulse_start(obs, off, reps);
      cfg_obs = CNT_W'(3);  // R4: later changes must not matter
      cfg_off = CNT_W'(2);
      for (int c = 0; c < total; c++) begin
         int r;
         int t;
         bit e_rch, e_smp, e_inh, e_rd, is_smp;
         r      = c / per;
         t      = c % per;
         e_inh  = (t < obs);
         e_rch  = (t < RCH);
         e_smp  = (t < obs - MARG);
         e_rd   = !e_inh && (t - obs >= GAP) && (t - obs < GAP + RDC);
         is_smp = !e_inh && (t - obs == GAP + RDC - 1);
         if (!e_inh) begin e_rch = 0; e_smp = 0; end
         // R6: drive the opposite value everywhere except the sampling cycle
         pix_bit = is_smp ? pat[r % 32] : !pat[r % 32];
         chk({name, " R1 R2 R3 R4 R5 strobes"}, strobes(),
             {25'd0, e_rch, e_smp, e_inh, e_rd, 1'b1, 1'b0, 1'b0});
         chk({name, " R6 R7 count"}, int'(hit_count), exp_cnt);
         chk({name, " R7 sat"}, int'(sat), int'(exp_cnt == HMAX));
         if (c == mid_at) start = 1'b1;  // R8: ignored while busy
         @(negedge clk);
         start = 1'b0;
         if (is_smp && pat[r % 32] && exp_cnt < HMAX) exp_cnt++;
      end
      for (int k = 0; k < 3; k++) begin
         chk({name, " R8 done held"}, strobes(), 32'h0000_0002);
         chk({name, " R8 final count"}, int'(hit_count), exp_cnt);
         pix_bit = 1'b1;
         @(negedge clk);
      end
   endtask

   task automatic reject_case(input string name, input int obs, input int off, input int reps);
      pulse_start(obs, off, reps);
      for (int k = 0; k < 12; k++) begin
         chk({name, " R9 error quiet"}, strobes(), 32'h0000_0001);
         chk({name, " R10 count cleared"}, int'(hit_count), 0);
         pix_bit = 1'b1;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("reset R3 strobes idle", strobes(), 0);
      chk("reset R10 count", int'(hit_count), 0);
      chk("reset R7 sat", int'(sat), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("idle R3 inhibit low", int'(inhibit_n), 0);

      run_case("basic", 10, 12, 3, 32'b101, -1);
      run_case("minoff", 20, 5, 4, 32'b1111, 30);
      run_case("minobs", 5, 6, 2, 32'b10, -1);
      run_case("saturate", 5, 5, 20, 32'hFFFF_FFFF, -1);
      reject_case("obs_short R9", 4, 8, 2);
      run_case("after_err", 6, 7, 3, 32'b011, 4);
      reject_case("off_short R9", 8, 4, 2);
      reject_case("reps_zero R9", 8, 8, 0);
      run_case("final", 12, 9, 5, 32'b10110, -1);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule